// File: doc/BRIEF.md
# Row Disturbance Stress Generator

This block produces an ordered stream of DRAM row-open (activate) and row-close (precharge) commands meant to stress one bank against read-disturb faults, the way a memory tester hammers rows next to a chosen victim. Software supplies a victim row, a bank, a pattern mode and an activation budget, then pulses `start`. The block derives the aggressor rows itself, drops any aggressor that would fall outside the row range, and hands each command to a downstream command scheduler over a valid/ready handshake.

Three pattern modes exist. One-sided hammering opens a single neighbour of the victim over and over. Two-sided hammering alternates between the rows just below and just above the victim. The frequency-based mode holds several two-sided aggressor pairs, each near its own victim row, and gives each pair its own period divisor, phase and burst length, so that the pairs are hammered non-uniformly across a sequence of base periods. A refresh strobe input can re-align the pattern so that its position restarts whenever a refresh is issued. The block counts accepted activations and raises a flag when the budget is used up.

Top module: `hammer_stress_gen`

## Requirements
- R1: After reset `cmd_valid` is 0, `done` is 0 and `act_count` is 0.
- R2: With `mode` = 0 (one-sided) every activate targets victim+1 when `single_up` is 1 and victim-1 when it is 0.
- R3: With `mode` = 1 or 3 (two-sided) the activates alternate victim-1, victim+1, victim-1, ... starting with victim-1.
- R4: Every accepted activate (`cmd_act` = 1) is followed by a precharge (`cmd_act` = 0) carrying the same row before the next activate, and every command carries the bank given at start.
- R5: An aggressor row below 0 or at or above `NUM_ROWS` is skipped, never wrapped; if the chosen mode has no aggressor in range, the run ends at once with `done` = 1 and no command issued.
- R6: With `mode` = 2 (frequency-based), pair k uses victim + k*`PAIR_STRIDE`; it is active in base period p when p >= phase_k and (p - phase_k) is a multiple of div_k (div 0 acts as 1); an active pair issues amp_k rounds of (lower row, upper row), pairs are served in ascending k, and a pair with amp 0 never issues.
- R7: With `ref_sync_en` = 1 at start, a `ref_strobe` during a run restarts the pattern before the next activate (base period 0, pair 0, lower row first); with `ref_sync_en` = 0 the strobe has no effect on the stream.
- R8: A run issues exactly `budget` activates, `act_count` counts them, and a budget of 0 ends the run at once with no command.
- R9: `done` stays 1 after a run ends until the next `start`, which clears it in the cycle it is taken (unless that run ends at once).
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_act`, `cmd_row` and `cmd_bank` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken only while idle |
| mode | input | 2 | 0 one-sided, 1 or 3 two-sided, 2 frequency-based |
| single_up | input | 1 | One-sided target: 1 above the victim, 0 below |
| victim | input | ROW_W | Victim row index |
| bank_sel | input | BANK_W | Bank for all commands |
| budget | input | BUD_W | Number of activates to issue |
| pair_div | input | NPAIR*FREQ_W | Per-pair period divisor, pair k at bits k*FREQ_W |
| pair_phase | input | NPAIR*FREQ_W | Per-pair phase in base periods |
| pair_amp | input | NPAIR*AMP_W | Per-pair rounds per active period |
| ref_strobe | input | 1 | Refresh-issued strobe |
| ref_sync_en | input | 1 | Enable refresh re-alignment |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Scheduler accepts the command |
| cmd_act | output | 1 | 1 activate, 0 precharge |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| act_count | output | BUD_W | Activates accepted in this run |
| done | output | 1 | Run finished |

## Verification
The hardest case to reach from the ports is a refresh strobe landing in the middle of a pattern, since its effect only shows as a break in the otherwise regular row sequence. The bench watches the handshake, raises the strobe in the same cycle the first activate is accepted, and expects the next activate to repeat the lower row rather than move on to the upper one; the same stimulus with re-alignment off must leave the alternation intact. The frequency-based mode is compared against a period-by-period model written from R6 with pairs whose rows partly fall off the top of the array.

// File: rtl/hammer_pkg.sv
`timescale 1ns/1ps
package hammer_pkg;

  typedef enum logic [1:0] {
    HM_SINGLE = 2'd0,
    HM_DOUBLE = 2'd1,
    HM_FREQ   = 2'd2,
    HM_DOUBLE_ALT = 2'd3
  } hm_mode_e;

  // Row index of an aggressor next to a victim; below zero wraps to a huge value
  function automatic int unsigned aggr_row(input int unsigned vrow, input logic upper);
    return upper ? vrow + 1 : vrow - 1;
  endfunction

  function automatic logic row_ok(input int unsigned row_x, input int unsigned nrows);
    return row_x < nrows;
  endfunction

  function automatic int unsigned pair_victim(input int unsigned vrow, input int unsigned k,
                                              input int unsigned stride);
    return vrow + k * stride;
  endfunction

endpackage

// File: rtl/hm_pair_timer.sv
`timescale 1ns/1ps
module hm_pair_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  input  logic [CW-1:0] div,
  output logic          fire
);
  logic [CW-1:0] ctr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= '0;
    else if (load) ctr_q <= load_val;
    else if (tick) begin
      if (ctr_q == '0) ctr_q <= (div == '0) ? '0 : div - 1'b1;
      else             ctr_q <= ctr_q - 1'b1;
    end
  end

  assign fire = (ctr_q == '0);

  // R6
  div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && fire && div <= 1) |=> fire);

endmodule

// File: rtl/hm_budget.sv
`timescale 1ns/1ps
module hm_budget #(
  parameter int BUD_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUD_W-1:0] load_val,
  input  logic             act_fire,
  output logic [BUD_W-1:0] act_count,
  output logic             empty
);
  logic [BUD_W-1:0] left_q, cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      left_q <= load_val;
      cnt_q  <= '0;
    end else if (act_fire) begin
      left_q <= left_q - 1'b1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign act_count = cnt_q;
  assign empty     = (left_q == '0);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> !empty);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fire && !load) |=> act_count == $past(act_count) + 1'b1);

endmodule

// File: rtl/hammer_stress_gen.sv
`timescale 1ns/1ps
module hammer_stress_gen
  import hammer_pkg::*;
#(
  parameter int NUM_ROWS    = 1000,
  parameter int BANK_W      = 3,
  parameter int NPAIR       = 4,
  parameter int PAIR_STRIDE = 4,
  parameter int FREQ_W      = 4,
  parameter int AMP_W       = 4,
  parameter int BUD_W       = 20,
  localparam int ROW_W      = $clog2(NUM_ROWS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              mode,
  input  logic                    single_up,
  input  logic [ROW_W-1:0]        victim,
  input  logic [BANK_W-1:0]       bank_sel,
  input  logic [BUD_W-1:0]        budget,
  input  logic [NPAIR*FREQ_W-1:0] pair_div,
  input  logic [NPAIR*FREQ_W-1:0] pair_phase,
  input  logic [NPAIR*AMP_W-1:0]  pair_amp,
  input  logic                    ref_strobe,
  input  logic                    ref_sync_en,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic                    cmd_act,
  output logic [BANK_W-1:0]       cmd_bank,
  output logic [ROW_W-1:0]        cmd_row,
  output logic [BUD_W-1:0]        act_count,
  output logic                    done
);
  localparam int PIDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_PICK, ST_ACT, ST_PRE} st_e;

  st_e               st_q;
  logic [1:0]        mode_q;
  logic              up_q, sync_q, ref_pend_q, done_q;
  logic [ROW_W-1:0]  vic_q, row_q;
  logic [BANK_W-1:0] bank_q;
  logic [FREQ_W-1:0] div_q [NPAIR];
  logic [FREQ_W-1:0] ph_q  [NPAIR];
  logic [AMP_W-1:0]  amp_q [NPAIR];
  logic [FREQ_W-1:0] div_in [NPAIR];
  logic [FREQ_W-1:0] ph_in  [NPAIR];
  logic [AMP_W-1:0]  amp_in [NPAIR];
  logic [PIDX_W-1:0] k_q, n_k;
  logic [AMP_W-1:0]  r_q, n_r;
  logic              h_q, n_h, wrap;
  logic [NPAIR-1:0]  fire;

  // Named internal events
  logic is_freq, is_single, pair_live, cand_ok, usable_in;
  logic start_ok, launch_ok, realign, pick_hit, pick_skip;
  logic act_hs, pre_hs, step_en, period_tick, timer_load, bud_empty;
  int unsigned pv, cand;

  for (genvar g = 0; g < NPAIR; g++) begin : g_unpack
    assign div_in[g] = pair_div[g*FREQ_W +: FREQ_W];
    assign ph_in[g]  = pair_phase[g*FREQ_W +: FREQ_W];
    assign amp_in[g] = pair_amp[g*AMP_W +: AMP_W];
  end

  assign is_freq   = (mode_q == HM_FREQ);
  assign is_single = (mode_q == HM_SINGLE);

  // Candidate aggressor at the current cursor
  always_comb begin
    pv        = is_freq ? pair_victim(32'(vic_q), 32'(k_q), PAIR_STRIDE) : 32'(vic_q);
    cand      = aggr_row(pv, is_single ? up_q : h_q);
    cand_ok   = row_ok(cand, NUM_ROWS);
    pair_live = !is_freq || (fire[k_q] && amp_q[k_q] != '0);
  end

  // Next cursor position: half, round, pair, period
  always_comb begin
    n_k  = k_q;
    n_r  = r_q;
    n_h  = h_q;
    wrap = 1'b0;
    if (!is_freq) begin
      n_h = is_single ? 1'b0 : ~h_q;
    end else if (pair_live && !h_q) begin
      n_h = 1'b1;
    end else if (pair_live && (32'(r_q) + 1 < 32'(amp_q[k_q]))) begin
      n_r = r_q + 1'b1;
      n_h = 1'b0;
    end else begin
      n_r = '0;
      n_h = 1'b0;
      if (32'(k_q) == NPAIR - 1) begin
        n_k  = '0;
        wrap = 1'b1;
      end else begin
        n_k = k_q + 1'b1;
      end
    end
  end

  // Does the requested pattern have any row inside the array?
  always_comb begin
    usable_in = 1'b0;
    case (mode)
      HM_SINGLE: usable_in = row_ok(aggr_row(32'(victim), single_up), NUM_ROWS);
      HM_FREQ: begin
        for (int k = 0; k < NPAIR; k++) begin
          if (amp_in[k] != '0 &&
              (row_ok(aggr_row(pair_victim(32'(victim), k, PAIR_STRIDE), 1'b0), NUM_ROWS) ||
               row_ok(aggr_row(pair_victim(32'(victim), k, PAIR_STRIDE), 1'b1), NUM_ROWS)))
            usable_in = 1'b1;
        end
      end
      default: usable_in = row_ok(aggr_row(32'(victim), 1'b0), NUM_ROWS) ||
                           row_ok(aggr_row(32'(victim), 1'b1), NUM_ROWS);
    endcase
  end

  assign start_ok    = (st_q == ST_IDLE) && start;
  assign launch_ok   = start_ok && (budget != '0) && usable_in;
  assign realign     = (st_q == ST_PICK) && ref_pend_q && sync_q;
  assign pick_hit    = (st_q == ST_PICK) && !realign && pair_live && cand_ok;
  assign pick_skip   = (st_q == ST_PICK) && !realign && !(pair_live && cand_ok);
  assign act_hs      = (st_q == ST_ACT) && cmd_ready;
  assign pre_hs      = (st_q == ST_PRE) && cmd_ready;
  assign step_en     = pick_skip || act_hs;
  assign period_tick = step_en && wrap && is_freq;
  assign timer_load  = start_ok || realign;

  for (genvar g = 0; g < NPAIR; g++) begin : g_timer
    hm_pair_timer #(.CW(FREQ_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_val ((st_q == ST_IDLE) ? ph_in[g] : ph_q[g]),
      .tick     (period_tick),
      .div      (div_q[g]),
      .fire     (fire[g])
    );
  end

  hm_budget #(.BUD_W(BUD_W)) u_budget (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .load_val  (budget),
    .act_fire  (act_hs),
    .act_count (act_count),
    .empty     (bud_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      up_q   <= 1'b0;
      sync_q <= 1'b0;
      vic_q  <= '0;
      bank_q <= '0;
      row_q  <= '0;
      k_q    <= '0;
      r_q    <= '0;
      h_q    <= 1'b0;
      done_q <= 1'b0;
      for (int k = 0; k < NPAIR; k++) begin
        div_q[k] <= '0;
        ph_q[k]  <= '0;
        amp_q[k] <= '0;
      end
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          mode_q <= mode;
          up_q   <= single_up;
          sync_q <= ref_sync_en;
          vic_q  <= victim;
          bank_q <= bank_sel;
          k_q    <= '0;
          r_q    <= '0;
          h_q    <= 1'b0;
          for (int k = 0; k < NPAIR; k++) begin
            div_q[k] <= div_in[k];
            ph_q[k]  <= ph_in[k];
            amp_q[k] <= amp_in[k];
          end
          done_q <= !launch_ok;
          st_q   <= launch_ok ? ST_PICK : ST_IDLE;
        end
        ST_PICK: begin
          if (realign) begin
            k_q <= '0;
            r_q <= '0;
            h_q <= 1'b0;
          end else if (pick_hit) begin
            row_q <= ROW_W'(cand);
            st_q  <= ST_ACT;
          end else begin
            k_q <= n_k;
            r_q <= n_r;
            h_q <= n_h;
          end
        end
        ST_ACT: if (act_hs) begin
          k_q  <= n_k;
          r_q  <= n_r;
          h_q  <= n_h;
          st_q <= ST_PRE;
        end
        ST_PRE: if (pre_hs) begin
          if (bud_empty) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_PICK;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Refresh strobes seen during a run wait here until the next pick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_pend_q <= 1'b0;
    else if (start_ok) ref_pend_q <= 1'b0;
    else ref_pend_q <= (ref_pend_q && !realign) || (ref_strobe && st_q != ST_IDLE);
  end

  assign cmd_valid = (st_q == ST_ACT) || (st_q == ST_PRE);
  assign cmd_act   = (st_q == ST_ACT);
  assign cmd_row   = row_q;
  assign cmd_bank  = bank_q;
  assign done      = done_q;

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_act) && $stable(cmd_row) && $stable(cmd_bank)));

  // R4
  act_then_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_act) |=> (cmd_valid && !cmd_act && cmd_row == $past(cmd_row)));

  // R5
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (32'(cmd_row) < NUM_ROWS));

  // R2
  not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !is_freq) |-> (cmd_row != vic_q));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

endmodule

// File: tb/test_hammer_stress_gen.sv
`timescale 1ns/1ps
module test_hammer_stress_gen;
  localparam int NR = 1000;
  localparam int ST = 4;

  logic        clk = 0, rst_n = 0, start = 0, single_up = 0;
  logic [1:0]  mode = 0;
  logic [9:0]  victim = 0;
  logic [2:0]  bank_sel = 0;
  logic [19:0] budget = 0;
  logic [15:0] pair_div = 0, pair_phase = 0, pair_amp = 0;
  logic        ref_strobe = 0, ref_sync_en = 0, cmd_ready = 1;
  logic        cmd_valid, cmd_act, done;
  logic [2:0]  cmd_bank;
  logic [9:0]  cmd_row;
  logic [19:0] act_count;

  hammer_stress_gen i_hammer_stress_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .single_up(single_up),
    .victim(victim), .bank_sel(bank_sel), .budget(budget), .pair_div(pair_div),
    .pair_phase(pair_phase), .pair_amp(pair_amp), .ref_strobe(ref_strobe),
    .ref_sync_en(ref_sync_en), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_act(cmd_act), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .act_count(act_count), .done(done));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int log_row [1024];
  bit log_act [1024];
  int log_bank [1024];
  int log_n = 0;
  int exp_row [512];
  int exp_n = 0;
  int pd [4], pp [4], pa [4];
  bit bp_en = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Ready driver, away from the active edge
  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    cmd_ready = bp_en ? ((cyc % 3) != 0 && (cyc % 7) != 2) : 1'b1;
  end

  // Handshake logger
  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready && log_n < 1024) begin
      log_row[log_n]  = int'(cmd_row);
      log_act[log_n]  = cmd_act;
      log_bank[log_n] = int'(cmd_bank);
      log_n++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    summary();
    $finish;
  end

  function automatic bit in_rng(input int r);
    return r >= 0 && r < NR;
  endfunction

  function automatic bit add_exp(input int r);
    if (!in_rng(r)) return 0;
    exp_row[exp_n] = r;
    exp_n++;
    return 1;
  endfunction

  task automatic set_pairs();
    for (int k = 0; k < 4; k++) begin
      pair_div[k*4 +: 4]   = 4'(pd[k]);
      pair_phase[k*4 +: 4] = 4'(pp[k]);
      pair_amp[k*4 +: 4]   = 4'(pa[k]);
    end
  endtask

  // Model of R6 written per base period
  task automatic build_freq(input int v, input int n);
    bit b;
    exp_n = 0;
    for (int p = 0; p < 2000 && exp_n < n; p++)
      for (int k = 0; k < 4; k++) begin
        int d;
        d = (pd[k] == 0) ? 1 : pd[k];
        if (pa[k] != 0 && p >= pp[k] && ((p - pp[k]) % d) == 0)
          for (int r = 0; r < pa[k]; r++)
            for (int h = 0; h < 2; h++)
              if (exp_n < n) b = add_exp(h ? v + k*ST + 1 : v + k*ST - 1);
      end
  endtask

  task automatic build_double(input int v, input int n);
    bit b;
    exp_n = 0;
    for (int i = 0; i < 4*n + 4 && exp_n < n; i++) b = add_exp((i % 2) ? v + 1 : v - 1);
  endtask

  task automatic launch(input int m, input int v, input bit up, input int bud, input int bk, input bit sync);
    @(negedge clk);
    mode = 2'(m); victim = 10'(v); single_up = up; budget = 20'(bud);
    bank_sel = 3'(bk); ref_sync_en = sync;
    log_n = 0;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input string req);
    int i;
    for (i = 0; i < 5000 && !done; i++) @(negedge clk);
    check(done == 1'b1, req, "run finished", int'(done), 1);
  endtask

  task automatic compare_stream(input string req, input int bk);
    check(log_n == 2*exp_n, req, "command count", log_n, 2*exp_n);
    for (int i = 0; i < exp_n && 2*i+1 < log_n; i++) begin
      check(log_act[2*i] && log_row[2*i] == exp_row[i], req, $sformatf("activate %0d row", i), log_row[2*i], exp_row[i]);
      check(!log_act[2*i+1] && log_row[2*i+1] == exp_row[i], "R4", $sformatf("precharge %0d row", i), log_row[2*i+1], exp_row[i]);
      check(log_bank[2*i] == bk && log_bank[2*i+1] == bk, "R4", "bank field", log_bank[2*i], bk);
    end
    check(int'(act_count) == exp_n, "R8", "act_count at end", int'(act_count), exp_n);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(cmd_valid == 0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
    check(done == 0, "R1", "done after reset", int'(done), 0);
    check(act_count == 0, "R1", "act_count after reset", int'(act_count), 0);
  endtask

  task automatic t_single();
    bit b;
    launch(0, 10, 1, 5, 2, 0);
    check(done == 0, "R9", "done cleared by start", int'(done), 0);
    wait_done("R2");
    exp_n = 0;
    for (int i = 0; i < 5; i++) b = add_exp(11);
    compare_stream("R2", 2);
    launch(0, 10, 0, 4, 5, 0);
    wait_done("R2");
    exp_n = 0;
    for (int i = 0; i < 4; i++) b = add_exp(9);
    compare_stream("R2", 5);
  endtask

  task automatic t_double();
    launch(1, 20, 0, 6, 1, 0);
    wait_done("R3");
    build_double(20, 6);
    compare_stream("R3", 1);
    launch(3, 40, 0, 3, 0, 0);
    wait_done("R3");
    build_double(40, 3);
    compare_stream("R3", 0);
  endtask

  task automatic t_edges();
    launch(1, 0, 0, 3, 3, 0);
    wait_done("R5");
    build_double(0, 3);
    compare_stream("R5", 3);
    launch(1, NR-1, 0, 2, 3, 0);
    wait_done("R5");
    build_double(NR-1, 2);
    compare_stream("R5", 3);
    launch(0, 0, 0, 7, 3, 0);
    check(done == 1, "R5", "no aggressor: done at once", int'(done), 1);
    repeat (4) @(negedge clk);
    check(log_n == 0, "R5", "no aggressor: commands", log_n, 0);
    check(act_count == 0, "R5", "no aggressor: act_count", int'(act_count), 0);
  endtask

  task automatic t_freq();
    pd = '{1, 2, 0, 0}; pp = '{0, 1, 0, 0}; pa = '{2, 1, 0, 0};
    set_pairs();
    launch(2, 100, 0, 14, 4, 0);
    wait_done("R6");
    build_freq(100, 14);
    compare_stream("R6", 4);
    pd = '{1, 3, 2, 0}; pp = '{0, 0, 1, 2}; pa = '{0, 1, 2, 1};
    set_pairs();
    launch(2, 990, 0, 10, 6, 0);
    wait_done("R6");
    build_freq(990, 10);
    compare_stream("R6", 6);
  endtask

  task automatic t_refresh(input bit sync);
    bit b;
    int i;
    launch(1, 50, 0, 5, 7, sync);
    for (i = 0; i < 200; i++) begin
      if (cmd_valid && cmd_ready && cmd_act) break;
      @(negedge clk);
    end
    ref_strobe = 1;
    @(negedge clk);
    ref_strobe = 0;
    wait_done("R7");
    exp_n = 0;
    if (sync) begin
      b = add_exp(49); b = add_exp(49); b = add_exp(51); b = add_exp(49); b = add_exp(51);
    end else build_double(50, 5);
    compare_stream("R7", 7);
  endtask

  task automatic t_budget();
    launch(1, 30, 0, 0, 1, 0);
    check(done == 1, "R8", "zero budget: done at once", int'(done), 1);
    repeat (3) @(negedge clk);
    check(log_n == 0, "R8", "zero budget: commands", log_n, 0);
    launch(1, 30, 0, 1, 1, 0);
    wait_done("R8");
    build_double(30, 1);
    compare_stream("R8", 1);
    repeat (6) @(negedge clk);
    check(done == 1, "R9", "done held while idle", int'(done), 1);
    check(cmd_valid == 0, "R9", "quiet while done", int'(cmd_valid), 0);
    launch(0, 30, 1, 2, 1, 0);
    check(done == 0, "R9", "done cleared by new start", int'(done), 0);
    check(act_count == 0, "R8", "act_count cleared by start", int'(act_count), 0);
    wait_done("R9");
  endtask

  task automatic t_backpressure();
    int i;
    bit held;
    int h_row, h_act, h_bank;
    bp_en = 1;
    launch(1, 300, 0, 8, 2, 0);
    held = 0;
    for (i = 0; i < 5000 && !done; i++) begin
      if (held)
        check(cmd_valid && int'(cmd_row) == h_row && int'(cmd_act) == h_act && int'(cmd_bank) == h_bank,
              "R10", "fields held under backpressure", int'(cmd_row), h_row);
      held  = cmd_valid && !cmd_ready;
      h_row = int'(cmd_row); h_act = int'(cmd_act); h_bank = int'(cmd_bank);
      @(negedge clk);
    end
    bp_en = 0;
    check(done == 1, "R10", "run finished under backpressure", int'(done), 1);
    build_double(300, 8);
    compare_stream("R10", 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_single();
    t_double();
    t_edges();
    t_freq();
    t_refresh(1'b1);
    t_refresh(1'b0);
    t_budget();
    t_backpressure();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule